// File: doc/BRIEF.md
# Bidirectional 8-bit timer with compare

This block is an 8-bit timer/counter with one compare channel. On every enabled tick the counter moves by one. It counts up in the plain and clear-on-match modes and in the fast waveform mode. In the phase-correct mode it climbs to the all-ones value, turns round, and falls back to zero. A tick comes from one of two enable inputs. One stands for the system clock and the other for an external source, and a select input picks between them. Software can load the count and the compare value through simple write strobes and can read both back.

The compare value is double-buffered. Software writes land in a buffer, and the buffer reaches the active compare register straight away in the two non-waveform modes. In the two waveform modes it is taken over only on the tick at the top of the count, so a period never starts with one threshold and ends with another. A tick on which the count equals the active compare value is a compare event. It sets a sticky compare flag and drives a waveform output that can toggle, set or clear. Used with the right mode this gives a variable-frequency square wave or an inverted or non-inverted PWM signal. A sticky overflow flag marks the wrap at the top of the count, or the turn at zero in phase-correct mode. Each flag has its own clear strobe.

Top module: `tmr8_cmp`

## Requirements
- R1: While reset is asserted and at its release, the count reads 0x00, the compare read port reads 0x00, both flags are 0 and the waveform output is 0.
- R2: In mode 0 (plain) and mode 3 (fast waveform), each tick adds one to the count and 0xFF wraps to 0x00. Without a tick the count holds.
- R3: When src_sel is 0 the tick is int_tick. When src_sel is 1 the tick is ext_tick, and int_tick is ignored.
- R4: A count write loads cnt_wdata on the next edge and takes precedence over a tick in that cycle. The first tick after the write produces no compare event, even when the count then equals the compare value.
- R5: The overflow flag is set by a tick at count 0xFF in modes 0, 1 and 3. In mode 2 it is set by a tick while counting down at 0x00. ovf_clr clears the flag, and a set in the same cycle wins over the clear.
- R6: A compare event is a tick, not suppressed by R4, on which the count equals the active compare value. It sets the compare flag. cmp_clr clears the flag, and a set wins over the clear.
- R7: In mode 1 (clear on match), a tick at which the count equals the active compare value moves the count to 0x00 instead of adding one.
- R8: In mode 2 (phase-correct), the count rises to 0xFF. A tick at 0xFF gives 0xFE and starts a descent. A tick at 0x00 while descending gives 0x01 and starts an ascent.
- R9: The compare read port returns the buffered value one edge after a write. In modes 0 and 1 the active value follows the buffer at once. In modes 2 and 3 the active value is taken from the buffer only on a tick at 0xFF while counting up.
- R10: In modes 0 and 1, with out_mode 1/2/3 a compare event toggles, clears or sets the waveform. With out_mode 0 the output is 0.
- R11: In mode 3, with out_mode 2 a compare event clears the waveform and the wrap tick at 0xFF sets it. If both happen on the same tick, the wrap wins. out_mode 3 swaps set and clear. out_mode 0 and 1 give an output of 0.
- R12: In mode 2, with out_mode 2 a compare event clears the waveform while counting up and sets it while counting down. out_mode 3 swaps these. out_mode 0 and 1 give an output of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_tick | input | 1 | Tick enable from the system clock side |
| ext_tick | input | 1 | Tick enable from the external source (already synchronous) |
| src_sel | input | 1 | 0 selects int_tick, 1 selects ext_tick |
| mode | input | 2 | 0 plain, 1 clear on match, 2 phase-correct, 3 fast waveform |
| out_mode | input | 2 | 0 off, 1 toggle, 2 clear, 3 set (see R10 to R12) |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | W | Count write data |
| cnt_rdata | output | W | Current count |
| cmp_wr | input | 1 | Compare buffer write strobe |
| cmp_wdata | input | W | Compare write data |
| cmp_rdata | output | W | Buffered compare value |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| cmp_clr | input | 1 | Compare flag clear strobe |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |
| wave_out | output | 1 | Waveform output |

## Verification
The hardest cases to reach from the ports are the ones inside a waveform period. One is a compare write that has to wait in the buffer until the count reaches the top of its climb. The other is a count write that lands exactly on the compare value, where the event has to be swallowed. The stimulus reaches the first by writing new thresholds in the middle of long phase-correct and fast-waveform runs. It reaches the second by loading the count with the compare value, and with the value just below it, and watching the flag after one tick. Random tick gaps and flag clears run alongside a behavioural model. The model is compared with every output on every clock, so wrap-versus-match collisions and turn-around ticks are checked wherever they occur.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_CTC    = 2'd1,
    MD_PHASE  = 2'd2,
    MD_FAST   = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    OA_OFF    = 2'd0,
    OA_TOGGLE = 2'd1,
    OA_CLEAR  = 2'd2,
    OA_SET    = 2'd3
  } out_act_e;

  function automatic logic is_pwm(input tmr_mode_e m);
    return (m == MD_PHASE) || (m == MD_FAST);
  endfunction

endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  tmr_mode_e    mode,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic [W-1:0] top_cmp,
  output logic [W-1:0] cnt_q,
  output logic         down_q,
  output logic         blk_q,
  output logic         ovf_ev,
  output logic         top_ev,
  output logic         wrap_ev
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] BOTV = {W{1'b0}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_d;
  logic         down_d;
  logic         blk_d;
  logic         at_max;
  logic         at_bot;

  assign at_max = (cnt_q == MAXV);
  assign at_bot = (cnt_q == BOTV);

  always_comb begin
    cnt_d   = cnt_q;
    down_d  = (mode == MD_PHASE) ? down_q : 1'b0;
    blk_d   = blk_q;
    ovf_ev  = 1'b0;
    top_ev  = 1'b0;
    wrap_ev = 1'b0;
    if (cnt_wr) begin
      cnt_d = cnt_wdata;
      blk_d = 1'b1;
    end else if (tick) begin
      blk_d = 1'b0;
      unique case (mode)
        MD_NORMAL: begin
          cnt_d  = cnt_q + ONE;
          ovf_ev = at_max;
        end
        MD_CTC: begin
          cnt_d  = (cnt_q == top_cmp) ? BOTV : cnt_q + ONE;
          ovf_ev = at_max;
        end
        MD_FAST: begin
          cnt_d   = cnt_q + ONE;
          ovf_ev  = at_max;
          top_ev  = at_max;
          wrap_ev = at_max;
        end
        MD_PHASE: begin
          if (!down_q) begin
            if (at_max) begin
              down_d = 1'b1;
              cnt_d  = cnt_q - ONE;
              top_ev = 1'b1;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (at_bot) begin
              down_d = 1'b0;
              cnt_d  = cnt_q + ONE;
              ovf_ev = 1'b1;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= BOTV;
      down_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      blk_q  <= blk_d;
    end
  end

endmodule

// File: rtl/tmr8_compare.sv
module tmr8_compare
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    mode,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         load_top,
  input  logic [W-1:0] cnt,
  input  logic         adv,
  input  logic         blk,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q,
  output logic         cmp_ev
);

  logic [W-1:0] buf_d;
  logic [W-1:0] act_d;
  logic         pwm;

  assign pwm = is_pwm(mode);

  always_comb begin
    buf_d = cmp_wr ? cmp_wdata : buf_q;
    if (pwm) begin
      act_d = load_top ? buf_q : act_q;
    end else begin
      act_d = buf_d;
    end
  end

  assign cmp_ev = adv && !blk && (cnt == act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
    end
  end

endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen
  import tmr8_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tmr_mode_e mode,
  input  out_act_e  out_mode,
  input  logic      cmp_ev,
  input  logic      wrap_ev,
  input  logic      down,
  output logic      wave_out
);

  logic wave_q;
  logic wave_d;
  logic pwm;
  logic linked;

  assign pwm    = is_pwm(mode);
  assign linked = (out_mode != OA_OFF) && !(pwm && (out_mode == OA_TOGGLE));

  always_comb begin
    wave_d = wave_q;
    if (linked) begin
      unique case (mode)
        MD_NORMAL, MD_CTC: begin
          if (cmp_ev) begin
            unique case (out_mode)
              OA_TOGGLE: wave_d = !wave_q;
              OA_CLEAR:  wave_d = 1'b0;
              OA_SET:    wave_d = 1'b1;
              default:   wave_d = wave_q;
            endcase
          end
        end
        MD_FAST: begin
          if (cmp_ev)  wave_d = (out_mode == OA_SET);
          if (wrap_ev) wave_d = (out_mode == OA_CLEAR);
        end
        MD_PHASE: begin
          if (cmp_ev) wave_d = down ^ (out_mode == OA_SET);
        end
        default: wave_d = wave_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave_out = linked && wave_q;

endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         int_tick,
  input  logic         ext_tick,
  input  logic         src_sel,
  input  logic [1:0]   mode,
  input  logic [1:0]   out_mode,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  output logic [W-1:0] cnt_rdata,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] cmp_rdata,
  input  logic         ovf_clr,
  input  logic         cmp_clr,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         wave_out
);

  tmr_mode_e    mode_e;
  out_act_e     oact_e;
  logic         tick;
  logic [W-1:0] cnt_q;
  logic         down_q;
  logic         blk_q;
  logic         ovf_ev;
  logic         top_ev;
  logic         wrap_ev;
  logic [W-1:0] buf_q;
  logic [W-1:0] act_q;
  logic         cmp_ev;
  logic         ovf_d;
  logic         cmpf_d;
  logic         ovf_q;
  logic         cmpf_q;

  assign mode_e = tmr_mode_e'(mode);
  assign oact_e = out_act_e'(out_mode);
  assign tick   = src_sel ? ext_tick : int_tick;

  tmr8_counter #(.W(W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode      (mode_e),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .top_cmp   (act_q),
    .cnt_q     (cnt_q),
    .down_q    (down_q),
    .blk_q     (blk_q),
    .ovf_ev    (ovf_ev),
    .top_ev    (top_ev),
    .wrap_ev   (wrap_ev)
  );

  tmr8_compare #(.W(W)) u_compare (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_e),
    .cmp_wr    (cmp_wr),
    .cmp_wdata (cmp_wdata),
    .load_top  (top_ev),
    .cnt       (cnt_q),
    .adv       (tick && !cnt_wr),
    .blk       (blk_q),
    .buf_q     (buf_q),
    .act_q     (act_q),
    .cmp_ev    (cmp_ev)
  );

  tmr8_wavegen u_wavegen (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_e),
    .out_mode (oact_e),
    .cmp_ev   (cmp_ev),
    .wrap_ev  (wrap_ev),
    .down     (down_q),
    .wave_out (wave_out)
  );

  always_comb begin
    ovf_d  = ovf_ev ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);
    cmpf_d = cmp_ev ? 1'b1 : (cmp_clr ? 1'b0 : cmpf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      cmpf_q <= 1'b0;
    end else begin
      ovf_q  <= ovf_d;
      cmpf_q <= cmpf_d;
    end
  end

  assign cnt_rdata = cnt_q;
  assign cmp_rdata = buf_q;
  assign ovf_flag  = ovf_q;
  assign cmp_flag  = cmpf_q;

endmodule

// File: rtl/tmr8_cmp_chk.sv
module tmr8_cmp_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         int_tick,
  input logic         ext_tick,
  input logic         src_sel,
  input logic [1:0]   mode,
  input logic [1:0]   out_mode,
  input logic         cnt_wr,
  input logic [W-1:0] cnt_wdata,
  input logic [W-1:0] cnt_rdata,
  input logic         cmp_wr,
  input logic [W-1:0] cmp_wdata,
  input logic [W-1:0] cmp_rdata,
  input logic         ovf_clr,
  input logic         cmp_clr,
  input logic         ovf_flag,
  input logic         cmp_flag,
  input logic         wave_out
);

  logic tk;
  assign tk = src_sel ? ext_tick : int_tick;

  // R2 and R3: no selected tick and no write leaves the count alone
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tk && !cnt_wr) |=> $stable(cnt_rdata));

  // R2: plain mode steps by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && tk && !cnt_wr) |=> (cnt_rdata == W'($past(cnt_rdata) + 1'b1)));

  // R4: a count write lands on the next edge
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_rdata == $past(cnt_wdata)));

  // R5: clearing with no tick drops the overflow flag
  p_ovf_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !tk) |=> !ovf_flag);

  // R6: clearing with no tick drops the compare flag
  p_cmp_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_clr && !tk) |=> !cmp_flag);

  // R8: phase-correct turn at the maximum
  p_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && tk && !cnt_wr && cnt_rdata == {W{1'b1}})
      |=> (cnt_rdata == {{(W-1){1'b1}}, 1'b0}));

  // R9: the read port shows the buffered compare value
  p_buf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> (cmp_rdata == $past(cmp_wdata)));

  // R10: output off gives a low pin
  p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'd0) |-> !wave_out);

endmodule

bind tmr8_cmp tmr8_cmp_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .int_tick  (int_tick),
  .ext_tick  (ext_tick),
  .src_sel   (src_sel),
  .mode      (mode),
  .out_mode  (out_mode),
  .cnt_wr    (cnt_wr),
  .cnt_wdata (cnt_wdata),
  .cnt_rdata (cnt_rdata),
  .cmp_wr    (cmp_wr),
  .cmp_wdata (cmp_wdata),
  .cmp_rdata (cmp_rdata),
  .ovf_clr   (ovf_clr),
  .cmp_clr   (cmp_clr),
  .ovf_flag  (ovf_flag),
  .cmp_flag  (cmp_flag),
  .wave_out  (wave_out)
);

// File: tb/tmr8_cmp_bench.sv
module tmr8_cmp_bench;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         int_tick;
  logic         ext_tick;
  logic         src_sel;
  logic [1:0]   mode;
  logic [1:0]   out_mode;
  logic         cnt_wr;
  logic [W-1:0] cnt_wdata;
  logic [W-1:0] cnt_rdata;
  logic         cmp_wr;
  logic [W-1:0] cmp_wdata;
  logic [W-1:0] cmp_rdata;
  logic         ovf_clr;
  logic         cmp_clr;
  logic         ovf_flag;
  logic         cmp_flag;
  logic         wave_out;

  tmr8_cmp #(.W(W)) u_tmr8_cmp (
    .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_tick(ext_tick),
    .src_sel(src_sel), .mode(mode), .out_mode(out_mode),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata),
    .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag), .wave_out(wave_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  int m_cnt, m_down, m_blk, m_buf, m_act, m_wave, m_ovf, m_cmpf;
  int x_cnt, x_down, x_blk, x_buf, x_act, x_wave, x_ovf, x_cmpf;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit linked_now();
    bit pwm = (mode >= 2);
    return (out_mode != 0) && !(pwm && out_mode == 1);
  endfunction

  task automatic model_next();
    bit tk, adv, ev, top, wrap, ovf;
    tk   = src_sel ? ext_tick : int_tick;
    adv  = tk && !cnt_wr;
    ev   = adv && (m_blk == 0) && (m_cnt == m_act);
    top  = 0; wrap = 0; ovf = 0;
    x_cnt  = m_cnt;
    x_down = (mode == 2) ? m_down : 0;
    x_blk  = m_blk;
    if (cnt_wr) begin
      x_cnt = cnt_wdata; x_blk = 1;
    end else if (tk) begin
      x_blk = 0;
      if (mode == 2) begin
        if (m_down == 0) begin
          if (m_cnt == 255) begin x_down = 1; x_cnt = 254; top = 1; end
          else x_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin x_down = 0; x_cnt = 1; ovf = 1; end
          else x_cnt = m_cnt - 1;
        end
      end else begin
        ovf = (m_cnt == 255);
        if (mode == 1 && m_cnt == m_act) x_cnt = 0;
        else x_cnt = (m_cnt + 1) % 256;
        if (mode == 3 && m_cnt == 255) begin top = 1; wrap = 1; end
      end
    end
    x_buf = cmp_wr ? int'(cmp_wdata) : m_buf;
    if (mode >= 2) x_act = top ? m_buf : m_act;
    else           x_act = x_buf;
    x_wave = m_wave;
    if (linked_now()) begin
      if (mode < 2) begin
        if (ev) x_wave = (out_mode == 1) ? 1 - m_wave : (out_mode == 3 ? 1 : 0);
      end else if (mode == 3) begin
        if (ev)   x_wave = (out_mode == 3) ? 1 : 0;
        if (wrap) x_wave = (out_mode == 2) ? 1 : 0;
      end else begin
        if (ev) x_wave = (m_down == 1) ? (out_mode == 2 ? 1 : 0) : (out_mode == 3 ? 1 : 0);
      end
    end
    x_ovf  = ovf ? 1 : (ovf_clr ? 0 : m_ovf);
    x_cmpf = ev  ? 1 : (cmp_clr ? 0 : m_cmpf);
  endtask

  task automatic cycle();
    string rc, rw;
    model_next();
    @(posedge clk);
    @(negedge clk);
    m_cnt = x_cnt; m_down = x_down; m_blk = x_blk; m_buf = x_buf;
    m_act = x_act; m_wave = x_wave; m_ovf = x_ovf; m_cmpf = x_cmpf;
    rc = (mode == 1) ? "R7" : (mode == 2) ? "R8" : "R2";
    rw = (mode < 2) ? "R10" : (mode == 2) ? "R12" : "R11";
    chk(rc, "count", cnt_rdata, m_cnt);
    chk("R9", "cmp read", cmp_rdata, m_buf);
    chk("R5", "ovf flag", ovf_flag, m_ovf);
    chk("R6", "cmp flag", cmp_flag, m_cmpf);
    chk(rw, "wave", wave_out, linked_now() ? m_wave : 0);
    cnt_wr = 0; cmp_wr = 0; ovf_clr = 0; cmp_clr = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic run_rand(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      int_tick = (($urandom % gap) != 0);
      if (($urandom % 37) == 0) ovf_clr = 1;
      if (($urandom % 23) == 0) cmp_clr = 1;
      cycle();
    end
    int_tick = 1;
  endtask

  task automatic wr_cmp(input int v);
    cmp_wr = 1; cmp_wdata = W'(v); cycle();
  endtask

  task automatic wr_cnt(input int v);
    cnt_wr = 1; cnt_wdata = W'(v); cycle();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 0; int_tick = 0; ext_tick = 0; src_sel = 0; mode = 0; out_mode = 0;
    cnt_wr = 0; cnt_wdata = 0; cmp_wr = 0; cmp_wdata = 0; ovf_clr = 0; cmp_clr = 0;
    m_cnt = 0; m_down = 0; m_blk = 0; m_buf = 0; m_act = 0; m_wave = 0; m_ovf = 0; m_cmpf = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "count", cnt_rdata, 0);
    chk("R1", "cmp read", cmp_rdata, 0);
    chk("R1", "ovf flag", ovf_flag, 0);
    chk("R1", "cmp flag", cmp_flag, 0);
    chk("R1", "wave", wave_out, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "count after release", cnt_rdata, 0);

    // plain mode, toggle output
    out_mode = 1;
    wr_cmp(8'h40);
    int_tick = 1;
    run(300);
    ovf_clr = 1; cmp_clr = 1; run(2);

    // R3: source select
    src_sel = 1; ext_tick = 0; int_tick = 1;
    c0 = cnt_rdata;
    run(5);
    chk("R3", "count held with ext idle", cnt_rdata, c0);
    ext_tick = 1;
    run(5);
    chk("R3", "count after five ext ticks", cnt_rdata, (c0 + 5) % 256);
    ext_tick = 0; src_sel = 0;

    // R4: write suppresses the next compare
    int_tick = 0;
    cmp_clr = 1; run(1);
    wr_cnt(8'h40);
    int_tick = 1; run(1); int_tick = 0;
    chk("R4", "no flag after write to match value", cmp_flag, 0);
    chk("R4", "count stepped", cnt_rdata, 8'h41);
    wr_cnt(8'h3F);
    int_tick = 1; run(2); int_tick = 0;
    chk("R4", "flag on normal match", cmp_flag, 1);
    // R4: write wins over tick
    int_tick = 1; wr_cnt(8'h10);
    chk("R4", "write beats tick", cnt_rdata, 8'h10);

    // clear on match
    mode = 1; out_mode = 1; int_tick = 1;
    wr_cmp(8'h10);
    run(120);
    wr_cmp(8'h05);
    run_rand(120, 4);
    out_mode = 3; run(40);
    out_mode = 2; run(40);

    // phase-correct
    mode = 2; out_mode = 2;
    wr_cmp(8'h80);
    run(600);
    wr_cmp(8'h20);
    run(700);
    out_mode = 3; wr_cmp(8'hFF);
    run(600);
    out_mode = 1; run(50);
    out_mode = 2; wr_cmp(8'h00);
    run_rand(900, 5);

    // fast waveform
    mode = 3; out_mode = 2;
    wr_cmp(8'h30);
    run(600);
    out_mode = 3; wr_cmp(8'hFF);
    run(600);
    out_mode = 1; run(40);
    out_mode = 2; wr_cmp(8'h00);
    run_rand(800, 3);

    // plain mode again with set and clear actions
    mode = 0; out_mode = 3; wr_cmp(8'hA0);
    run_rand(400, 4);
    out_mode = 2; run(300);

    done = 1;
    summary();
    $finish;
  end

endmodule